// File: doc/BRIEF.md
# Quadrature Encoder Counter Channel

This block is a single counting channel for an incremental position encoder. Three raw inputs (phase A, phase B and index) are brought into the system clock domain and compared with their previous sampled values. The channel then either decodes the A/B pair as quadrature at one, two or four counts per encoder cycle, or acts as a totalizer that counts rising edges of phase A.

Each counted event passes through a selectable counting rule: free up/down wrap, stop-on-overflow, clamping between two limits, modulo-N wrap, clear-on-read, or forced decrement. A separate index action decides what a rising index does: capture the count, clear it, load a preset, take one count away, or open a gate so that events count only while the index is high. A one-cycle latch strobe or a read strobe copies the live count into a snapshot register, so that a host can read a wide value in several parts and still get one coherent sample.

Top module: `qenc_channel`

## Requirements
- R1: Phase and index inputs pass through two synchronizer flops. A change on a pin between two clock edges first shows in `count_o` after the third rising edge. After reset `count_o` and `snap_o` are zero.
- R2: With `res_sel_i`=2 (x4), every single-phase change counts. The order (A,B) = 00,10,11,01,00 counts up (A leads), and the reverse order counts down.
- R3: With `res_sel_i`=1 (x2), only A changes count, two per encoder cycle. With `res_sel_i`=0 (x1), one count per cycle: up on A rising while B is low, down on A falling while B is low.
- R4: In the quadrature resolutions, a sample in which A and B both change is not counted and gives a one-cycle pulse on `phase_err_o`.
- R5: With `res_sel_i`=3 (totalize), each rising edge of A counts. The count goes up while B is low and down while B is high.
- R6: With `mode_i`=1 (non-recycle), a count that would pass the all-ones value or go below zero is held, and further events are ignored until an index clear or reload.
- R7: With `mode_i`=2 (range), counting up stops at `lim_hi_i` and counting down stops at `lim_lo_i`, with no wrap.
- R8: With `mode_i`=3 (modulo), counting up from `mod_n_i`-1 gives 0, and counting down from 0 gives `mod_n_i`-1.
- R9: `latch_i` or `rd_i` copies `count_o` into `snap_o` at the next edge. With `mode_i`=4 (clear-on-read), `rd_i` also sets the count to 0 in that same edge, and the read takes priority over any event.
- R10: With `mode_i`=5 (decrement), every counted event subtracts one and wraps below zero, whatever the direction. `mode_i`=0 is free up/down with wrap.
- R11: On a rising index, `idx_act_i`=1 captures the count into `snap_o`, `idx_act_i`=2 clears it, and `idx_act_i`=3 loads `preset_i`. A clear or a load also releases a non-recycle hold.
- R12: On a rising index, `idx_act_i`=4 subtracts one. With `idx_act_i`=5, events count only while the synchronized index is high. `idx_act_i`=0 means no index action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha_i | input | 1 | Raw phase A |
| phb_i | input | 1 | Raw phase B |
| idx_i | input | 1 | Raw index |
| res_sel_i | input | 2 | 0 x1, 1 x2, 2 x4, 3 totalize |
| mode_i | input | 3 | Counting rule: 0 up/down, 1 non-recycle, 2 range, 3 modulo, 4 clear-on-read, 5 decrement |
| idx_act_i | input | 3 | Index action: 0 none, 1 latch, 2 clear, 3 reload, 4 decrement, 5 gate |
| lim_lo_i | input | CNT_W | Range lower limit |
| lim_hi_i | input | CNT_W | Range upper limit |
| mod_n_i | input | CNT_W | Modulus N |
| preset_i | input | CNT_W | Reload value |
| latch_i | input | 1 | Snapshot strobe from the pacer |
| rd_i | input | 1 | Read strobe, snapshots and clears in clear-on-read |
| count_o | output | CNT_W | Live count |
| snap_o | output | CNT_W | Snapshot register |
| phase_err_o | output | 1 | One-cycle pulse on an illegal phase transition |

## Verification
A wrong decode or direction table shows on `count_o` three edges after the pin change, as a count in the wrong direction or a count that is missing. A wrong hold or clamp state in non-recycle, range or modulo mode shows one event later, as a value outside the allowed set or a count that keeps moving after it should stop. A broken snapshot path shows on `snap_o` at the edge after the strobe. The bench steps through each resolution, rule and index action and compares every settled count against values worked out by hand.

// File: rtl/qenc_channel.sv
module qenc_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pha_i,
  input  logic             phb_i,
  input  logic             idx_i,
  input  logic [1:0]       res_sel_i,
  input  logic [2:0]       mode_i,
  input  logic [2:0]       idx_act_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  input  logic [CNT_W-1:0] mod_n_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             latch_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             phase_err_o
);
  localparam logic [1:0] RES_X1 = 2'd0, RES_X2 = 2'd1, RES_X4 = 2'd2, RES_TOT = 2'd3;
  localparam logic [2:0] M_NOREC = 3'd1, M_RANGE = 3'd2, M_MODN = 3'd3,
                         M_CLRRD = 3'd4, M_DECR = 3'd5;
  localparam logic [2:0] X_LATCH = 3'd1, X_CLR = 3'd2, X_LOAD = 3'd3,
                         X_DEC = 3'd4, X_GATE = 3'd5;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [1:0] a_ff, b_ff, i_ff;
  logic       a_q, b_q, i_q;
  logic       stuck, stuck_n;
  logic       ev, up;
  logic [CNT_W-1:0] nxt;

  wire a_s = a_ff[1];
  wire b_s = b_ff[1];
  wire i_s = i_ff[1];
  wire a_chg = a_s ^ a_q;
  wire b_chg = b_s ^ b_q;
  wire illegal = (res_sel_i != RES_TOT) & a_chg & b_chg;
  wire idx_rise = i_s & ~i_q;
  wire dec_pulse = (idx_act_i == X_DEC) & idx_rise;
  wire ev_g = ev & ((idx_act_i != X_GATE) | i_s);
  wire step = ev_g | dec_pulse;
  wire dir_up = up & ~dec_pulse & (mode_i != M_DECR);
  wire [CNT_W-1:0] plus = count_o + 1'b1;
  wire [CNT_W-1:0] minus = count_o - 1'b1;
  wire [CNT_W-1:0] n_top = mod_n_i - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ff <= '0; b_ff <= '0; i_ff <= '0;
      a_q <= 1'b0; b_q <= 1'b0; i_q <= 1'b0;
    end else begin
      a_ff <= {a_ff[0], pha_i};
      b_ff <= {b_ff[0], phb_i};
      i_ff <= {i_ff[0], idx_i};
      a_q <= a_s; b_q <= b_s; i_q <= i_s;
    end
  end

  always_comb begin
    ev = 1'b0;
    up = a_s ^ b_q;
    case (res_sel_i)
      RES_X1:  begin ev = a_chg & ~b_chg & ~b_s; up = a_s; end
      RES_X2:  ev = a_chg & ~b_chg;
      RES_X4:  ev = a_chg ^ b_chg;
      default: begin ev = a_s & ~a_q; up = ~b_s; end
    endcase
  end

  always_comb begin
    nxt = count_o;
    stuck_n = stuck;
    if (step) begin
      case (mode_i)
        M_NOREC:
          if (!stuck) begin
            if (dir_up && count_o == CMAX) stuck_n = 1'b1;
            else if (!dir_up && count_o == '0) stuck_n = 1'b1;
            else nxt = dir_up ? plus : minus;
          end
        M_RANGE:
          if (dir_up) nxt = (count_o >= lim_hi_i) ? lim_hi_i : plus;
          else        nxt = (count_o <= lim_lo_i) ? lim_lo_i : minus;
        M_MODN:
          if (dir_up) nxt = (count_o >= n_top) ? '0 : plus;
          else        nxt = (count_o == '0) ? n_top : minus;
        default: nxt = dir_up ? plus : minus;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      stuck <= 1'b0;
    end else if (rd_i && mode_i == M_CLRRD) begin
      count_o <= '0;
    end else if (idx_rise && idx_act_i == X_CLR) begin
      count_o <= '0;
      stuck <= 1'b0;
    end else if (idx_rise && idx_act_i == X_LOAD) begin
      count_o <= preset_i;
      stuck <= 1'b0;
    end else begin
      count_o <= nxt;
      stuck <= stuck_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o <= '0;
      phase_err_o <= 1'b0;
    end else begin
      phase_err_o <= illegal;
      if (latch_i || rd_i || (idx_rise && idx_act_i == X_LATCH)) snap_o <= count_o;
    end
  end
endmodule

// File: rtl/qenc_channel_chk.sv
module qenc_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic [2:0]       idx_act_i,
  input logic [CNT_W-1:0] lim_lo_i,
  input logic [CNT_W-1:0] lim_hi_i,
  input logic [CNT_W-1:0] mod_n_i,
  input logic             latch_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] snap_o,
  input logic             phase_err_o
);
  p_illegal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err_o && $past(idx_act_i) == 3'd0 && !$past(rd_i)) |-> count_o == $past(count_o));

  p_snap_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(latch_i) |-> snap_o == $past(count_o));

  p_clear_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_i && mode_i == 3'd4) |-> (count_o == '0 && snap_o == $past(count_o)));

  p_range_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 3'd2 && $past(idx_act_i) == 3'd0 &&
     $past(lim_lo_i) <= $past(lim_hi_i) &&
     $past(count_o) >= $past(lim_lo_i) && $past(count_o) <= $past(lim_hi_i))
    |-> (count_o >= $past(lim_lo_i) && count_o <= $past(lim_hi_i)));

  p_modn_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 3'd3 && $past(idx_act_i) == 3'd0 && $past(mod_n_i) != '0 &&
     $past(count_o) < $past(mod_n_i)) |-> count_o < $past(mod_n_i));
endmodule

bind qenc_channel qenc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .idx_act_i(idx_act_i),
  .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .mod_n_i(mod_n_i),
  .latch_i(latch_i), .rd_i(rd_i), .count_o(count_o), .snap_o(snap_o),
  .phase_err_o(phase_err_o)
);

// File: tb/qenc_channel_tb_top.sv
module qenc_channel_tb_top;
  localparam int CW = 32;
  localparam logic [CW-1:0] MAXV = '1;

  typedef struct {
    bit             is_snap;
    logic [CW-1:0]  val;
    string          tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic [1:0] res = 2'd2;
  logic [2:0] mode = 3'd0, act = 3'd0;
  logic [CW-1:0] lo = '0, hi = '0, modn = '0, pre = '0;
  logic lat = 1'b0, rd = 1'b0;
  logic [CW-1:0] count, snap;
  logic perr;

  int checks = 0, errors = 0, err_pulses = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  qenc_channel #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
    .res_sel_i(res), .mode_i(mode), .idx_act_i(act), .lim_lo_i(lo),
    .lim_hi_i(hi), .mod_n_i(modn), .preset_i(pre), .latch_i(lat),
    .rd_i(rd), .count_o(count), .snap_o(snap), .phase_err_o(perr)
  );

  always @(negedge clk) if (perr) err_pulses++;

  task automatic chk(input logic [CW-1:0] act_v, input logic [CW-1:0] exp_v, input string tag);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      #5;
      e = q.pop_front();
      chk(e.is_snap ? snap : count, e.val, e.tag);
    end
  end

  task automatic expect_cnt(input logic [CW-1:0] v, input string tag);
    exp_t e;
    e.is_snap = 1'b0; e.val = v; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic expect_snap(input logic [CW-1:0] v, input string tag);
    exp_t e;
    e.is_snap = 1'b1; e.val = v; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic move(input logic a, input logic b);
    pha = a; phb = b;
    settle();
  endtask

  task automatic tpulse();
    move(1'b1, phb);
    move(1'b0, phb);
  endtask

  task automatic ipulse();
    idx = 1'b1; settle();
    idx = 1'b0; settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_cnt('0, "R1 reset count");
    expect_snap('0, "R1 reset snap");

    pha = 1'b1;
    repeat (2) @(negedge clk);
    chk(count, 0, "R1 not yet after two edges");
    @(negedge clk);
    chk(count, 1, "R1 visible after third edge");
    settle();
    move(1, 1); move(0, 1); move(0, 0);
    expect_cnt(4, "R2 x4 up cycle");
    move(0, 1); move(1, 1);
    expect_cnt(2, "R2 x4 down half");
    move(1, 0); move(0, 0);
    expect_cnt(0, "R2 x4 down cycle");

    res = 2'd1;
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    expect_cnt(2, "R3 x2 up cycle");
    res = 2'd0;
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    expect_cnt(3, "R3 x1 up cycle");
    move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    expect_cnt(2, "R3 x1 down cycle");

    res = 2'd2;
    move(1, 1);
    expect_cnt(2, "R4 illegal not counted");
    chk(err_pulses, 1, "R4 one error pulse");
    move(0, 1); move(0, 0);
    expect_cnt(4, "R4 counting resumes");
    chk(err_pulses, 1, "R4 no extra pulse");

    res = 2'd3;
    tpulse(); tpulse();
    expect_cnt(6, "R5 totalize up");
    move(0, 1);
    tpulse(); tpulse();
    expect_cnt(4, "R5 totalize down");
    move(0, 0);

    act = 3'd3; pre = 5;
    ipulse();
    expect_cnt(5, "R11 index reload");
    act = 3'd2;
    ipulse();
    expect_cnt(0, "R11 index clear");
    act = 3'd3;
    ipulse();
    act = 3'd1;
    ipulse();
    expect_snap(5, "R11 index latch");
    tpulse();
    expect_cnt(6, "R11 count after latch");
    expect_snap(5, "R11 snap held");

    act = 3'd4;
    ipulse();
    expect_cnt(5, "R12 index decrement");
    act = 3'd5;
    tpulse();
    expect_cnt(5, "R12 gate closed");
    idx = 1'b1; settle();
    tpulse();
    expect_cnt(6, "R12 gate open");
    idx = 1'b0; settle();
    act = 3'd0;

    lat = 1'b1; @(negedge clk); lat = 1'b0;
    expect_snap(6, "R9 latch strobe");
    expect_cnt(6, "R9 latch keeps count");
    mode = 3'd4;
    tpulse();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    expect_snap(7, "R9 read snapshot");
    expect_cnt(0, "R9 clear on read");

    mode = 3'd5;
    tpulse();
    expect_cnt(MAXV, "R10 decrement wraps");
    mode = 3'd0;
    tpulse();
    expect_cnt(0, "R10 up/down wrap");

    mode = 3'd1; act = 3'd3; pre = 0;
    ipulse();
    move(0, 1);
    tpulse();
    expect_cnt(0, "R6 underflow held");
    move(0, 0);
    tpulse();
    expect_cnt(0, "R6 stays held");
    act = 3'd2;
    ipulse();
    tpulse();
    expect_cnt(1, "R6 released by clear");
    act = 3'd3; pre = MAXV - 1;
    ipulse();
    tpulse();
    expect_cnt(MAXV, "R6 reach max");
    tpulse();
    move(0, 1);
    tpulse();
    expect_cnt(MAXV, "R6 overflow held");
    move(0, 0);

    mode = 3'd2; lo = 10; hi = 12; pre = 11;
    ipulse();
    act = 3'd0;
    tpulse(); tpulse();
    expect_cnt(12, "R7 upper limit");
    move(0, 1);
    tpulse();
    expect_cnt(11, "R7 down inside");
    tpulse(); tpulse();
    expect_cnt(10, "R7 lower limit");
    move(0, 0);

    mode = 3'd3; modn = 3; act = 3'd3; pre = 0;
    ipulse();
    act = 3'd0;
    move(0, 1);
    tpulse();
    expect_cnt(2, "R8 down from zero");
    move(0, 0);
    tpulse();
    expect_cnt(0, "R8 up wraps");
    tpulse(); tpulse();
    expect_cnt(2, "R8 up to N-1");
    tpulse();
    expect_cnt(0, "R8 wraps again");

    settle();
    finish_run();
  end
endmodule